// File: doc/BRIEF.md
# Byte Lane Insert, Gather and Immediate Unit

This combinational unit computes the value written back to a destination register for four byte-lane and immediate operations. It takes the present destination word, a source word, a lane mask, an immediate byte and an operation code. It returns the new destination word in the same cycle. Instruction decode, register file access and write-back timing belong to the surrounding pipeline.

The unit has four operations. Insert copies the lowest source byte into every lane the mask picks and leaves the other lanes of the destination as they were. Gather adds the picked source lanes together as unsigned values. Load-immediate sign-extends the immediate byte to a full word. Shift-in-immediate moves the destination up by one byte and puts the immediate in the bottom byte. A chain of shift-in-immediate operations after a load-immediate builds any 32-bit constant.

Top module: `lanepack_unit`

## Requirements
- R1: With op = 2'b00 (insert), every lane i whose mask bit i is 1 equals source bits [7:0].
- R2: With op = 2'b00, every lane i whose mask bit i is 0 equals the same lane of the destination input.
- R3: Mask bit i selects lane i, which is word bits [8i+7:8i]. Mask bit 3 selects bits [31:24] and mask bit 0 selects bits [7:0].
- R4: With op = 2'b01 (gather), the result is the sum of the source lanes whose mask bit is 1. Each lane is zero-extended to 32 bits before the sum, and lanes whose mask bit is 0 add nothing.
- R5: A gather result never exceeds 0x3FC, so result bits [31:10] are always 0. Mask 4'hF with source 0xFFFFFFFF gives 0x3FC.
- R6: An insert with mask 0 returns the destination unchanged. A gather with mask 0 returns 0.
- R7: With op = 2'b10 (load-immediate), result bits [7:0] equal the immediate. Bits [31:8] are all ones when immediate bit 7 is 1 and all zeros when it is 0.
- R8: With op = 2'b11 (shift-in-immediate), the result is destination bits [23:0] followed by the immediate in bits [7:0]. The old destination bits [31:24] are dropped.
- R9: Inputs that an operation does not use have no effect on the result. Load-immediate ignores destination, source and mask. Gather ignores destination. Shift-in-immediate ignores source and mask.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op_i | input | 2 | Operation: 00 insert, 01 gather, 10 load-immediate, 11 shift-in-immediate |
| dst_i | input | 32 | Current destination register value |
| src_i | input | 32 | Source register value |
| mask_i | input | 4 | Lane mask, bit i selects lane i |
| imm_i | input | 8 | Immediate byte |
| result_o | output | 32 | New destination value |

## Verification
The bench builds the unit with its default parameters: four lanes of eight bits and an eight-bit immediate. With these values there are only sixteen masks, so the bench runs every mask against several destination and source patterns for both insert and gather. It also reaches the gather ceiling of 0x3FC with all lanes at 0xFF. It covers sign extension on both sides of immediate bit 7. A four-step shift-in chain builds a full constant and shows that the top byte is dropped.

// File: rtl/lanepack_pkg.sv
`timescale 1ns/1ps
package lanepack_pkg;

    localparam int unsigned OP_W = 2;

    typedef enum logic [OP_W-1:0] {
        OP_INSERT  = 2'd0,
        OP_GATHER  = 2'd1,
        OP_LDIMM   = 2'd2,
        OP_SHIFTIN = 2'd3
    } lane_op_e;

    // Bits needed to hold the sum of all lanes at their maximum value.
    function automatic int unsigned gather_width(int unsigned lane_w, int unsigned lanes);
        return lane_w + ((lanes > 1) ? $clog2(lanes) : 0);
    endfunction

endpackage

// File: rtl/lane_insert.sv
`timescale 1ns/1ps
module lane_insert #(
    parameter int unsigned LANE_W = 8,
    parameter int unsigned LANES  = 4,
    localparam int unsigned DATA_W = LANE_W * LANES
) (
    input  logic [DATA_W-1:0] dst_i,
    input  logic [LANE_W-1:0] fill_i,
    input  logic [LANES-1:0]  mask_i,
    output logic [DATA_W-1:0] word_o
);

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        assign word_o[g*LANE_W +: LANE_W] = mask_i[g] ? fill_i : dst_i[g*LANE_W +: LANE_W];
    end

endmodule

// File: rtl/lane_gather.sv
`timescale 1ns/1ps
module lane_gather
    import lanepack_pkg::*;
#(
    parameter int unsigned LANE_W = 8,
    parameter int unsigned LANES  = 4,
    localparam int unsigned DATA_W = LANE_W * LANES,
    localparam int unsigned SUM_W  = gather_width(LANE_W, LANES)
) (
    input  logic [DATA_W-1:0] src_i,
    input  logic [LANES-1:0]  mask_i,
    output logic [DATA_W-1:0] sum_o
);

    logic [SUM_W-1:0] acc;

    always_comb begin
        acc = '0;
        for (int i = 0; i < LANES; i++) begin
            if (mask_i[i]) begin
                acc = acc + SUM_W'(src_i[i*LANE_W +: LANE_W]);
            end
        end
    end

    assign sum_o = DATA_W'(acc);

endmodule

// File: rtl/imm_build.sv
`timescale 1ns/1ps
module imm_build #(
    parameter int unsigned DATA_W = 32,
    parameter int unsigned IMM_W  = 8,
    localparam int unsigned EXT_W = DATA_W - IMM_W
) (
    input  logic [DATA_W-1:0] dst_i,
    input  logic [IMM_W-1:0]  imm_i,
    input  logic              shift_in_i,
    output logic [DATA_W-1:0] word_o
);

    logic [DATA_W-1:0] sext;
    logic [DATA_W-1:0] shifted;

    assign sext    = {{EXT_W{imm_i[IMM_W-1]}}, imm_i};
    assign shifted = {dst_i[EXT_W-1:0], imm_i};
    assign word_o  = shift_in_i ? shifted : sext;

endmodule

// File: rtl/lanepack_unit.sv
`timescale 1ns/1ps
module lanepack_unit
    import lanepack_pkg::*;
#(
    parameter int unsigned LANE_W = 8,
    parameter int unsigned LANES  = 4,
    parameter int unsigned IMM_W  = 8,
    localparam int unsigned DATA_W = LANE_W * LANES
) (
    input  logic [OP_W-1:0]   op_i,
    input  logic [DATA_W-1:0] dst_i,
    input  logic [DATA_W-1:0] src_i,
    input  logic [LANES-1:0]  mask_i,
    input  logic [IMM_W-1:0]  imm_i,
    output logic [DATA_W-1:0] result_o
);

    lane_op_e          op;
    logic [DATA_W-1:0] ins_word;
    logic [DATA_W-1:0] gat_word;
    logic [DATA_W-1:0] imm_word;

    assign op = lane_op_e'(op_i);

    lane_insert #(.LANE_W(LANE_W), .LANES(LANES)) u_insert (
        .dst_i  (dst_i),
        .fill_i (src_i[LANE_W-1:0]),
        .mask_i (mask_i),
        .word_o (ins_word)
    );

    lane_gather #(.LANE_W(LANE_W), .LANES(LANES)) u_gather (
        .src_i  (src_i),
        .mask_i (mask_i),
        .sum_o  (gat_word)
    );

    imm_build #(.DATA_W(DATA_W), .IMM_W(IMM_W)) u_imm (
        .dst_i      (dst_i),
        .imm_i      (imm_i),
        .shift_in_i (op == OP_SHIFTIN),
        .word_o     (imm_word)
    );

    always_comb begin
        unique case (op)
            OP_INSERT: result_o = ins_word;
            OP_GATHER: result_o = gat_word;
            default:   result_o = imm_word;
        endcase
    end

endmodule

// File: rtl/lanepack_unit_chk.sv
`timescale 1ns/1ps
module lanepack_unit_chk
    import lanepack_pkg::*;
#(
    parameter int unsigned LANE_W = 8,
    parameter int unsigned LANES  = 4,
    parameter int unsigned IMM_W  = 8,
    localparam int unsigned DATA_W = LANE_W * LANES
) (
    input logic [OP_W-1:0]   op_i,
    input logic [DATA_W-1:0] dst_i,
    input logic [DATA_W-1:0] src_i,
    input logic [LANES-1:0]  mask_i,
    input logic [IMM_W-1:0]  imm_i,
    input logic [DATA_W-1:0] result_o
);

    localparam logic [DATA_W-1:0] GATHER_MAX = DATA_W'(LANES * ((1 << LANE_W) - 1));

    logic known;
    assign known = !$isunknown({op_i, dst_i, src_i, mask_i, imm_i, result_o});

    always_comb begin
        if (known && op_i == 2'd0) begin
            for (int i = 0; i < LANES; i++) begin
                if (mask_i[i]) begin
                    // R1 and R3: a picked lane carries the low source byte
                    a_r1_insert_fill: assert (result_o[i*LANE_W +: LANE_W] == src_i[LANE_W-1:0]);
                end else begin
                    a_r2_insert_keep: assert (result_o[i*LANE_W +: LANE_W] == dst_i[i*LANE_W +: LANE_W]);
                end
            end
        end
    end

    always_comb begin
        if (known && op_i == 2'd1) begin
            a_r5_gather_bound: assert (result_o <= GATHER_MAX);
            if (mask_i == '0) begin
                a_r6_gather_empty: assert (result_o == '0);
            end
        end
    end

    always_comb begin
        if (known && op_i == 2'd2) begin
            a_r7_ldimm_sext: assert (result_o[IMM_W-1:0] == imm_i &&
                (result_o[DATA_W-1:IMM_W] == '0 || &result_o[DATA_W-1:IMM_W]) &&
                result_o[DATA_W-1] == imm_i[IMM_W-1]);
        end
    end

    always_comb begin
        if (known && op_i == 2'd3) begin
            a_r8_shiftin_word: assert (result_o[IMM_W-1:0] == imm_i &&
                result_o[DATA_W-1:IMM_W] == dst_i[DATA_W-IMM_W-1:0]);
        end
    end

endmodule

bind lanepack_unit lanepack_unit_chk #(
    .LANE_W (LANE_W),
    .LANES  (LANES),
    .IMM_W  (IMM_W)
) u_chk (
    .op_i     (op_i),
    .dst_i    (dst_i),
    .src_i    (src_i),
    .mask_i   (mask_i),
    .imm_i    (imm_i),
    .result_o (result_o)
);

// File: tb/lanepack_unit_tb.sv
`timescale 1ns/1ps
module lanepack_unit_tb;

    logic        clk;
    logic [1:0]  op;
    logic [31:0] dst;
    logic [31:0] src;
    logic [3:0]  mask;
    logic [7:0]  imm;
    logic [31:0] result;

    int checks = 0;
    int errors = 0;
    bit done   = 0;

    lanepack_unit u_dut (
        .op_i     (op),
        .dst_i    (dst),
        .src_i    (src),
        .mask_i   (mask),
        .imm_i    (imm),
        .result_o (result)
    );

    initial clk = 1'b0;
    always #4 clk = ~clk;

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic apply(input logic [1:0] o, input logic [31:0] d, input logic [31:0] s,
                         input logic [3:0] m, input logic [7:0] i);
        @(posedge clk);
        op = o; dst = d; src = s; mask = m; imm = i;
        @(negedge clk);
    endtask

    function automatic logic [31:0] model_insert(logic [31:0] d, logic [31:0] s, logic [3:0] m);
        logic [31:0] r = d;
        if (m[0]) r[7:0]   = s[7:0];
        if (m[1]) r[15:8]  = s[7:0];
        if (m[2]) r[23:16] = s[7:0];
        if (m[3]) r[31:24] = s[7:0];
        return r;
    endfunction

    function automatic logic [31:0] model_gather(logic [31:0] s, logic [3:0] m);
        int unsigned t = 0;
        if (m[0]) t += s[7:0];
        if (m[1]) t += s[15:8];
        if (m[2]) t += s[23:16];
        if (m[3]) t += s[31:24];
        return t;
    endfunction

    task automatic t_idle();
        apply(2'b00, 32'h0, 32'h0, 4'h0, 8'h0);
        check("R6 idle insert", result, 32'h0);
    endtask

    task automatic t_insert_sweep(input logic [31:0] d, input logic [31:0] s);
        for (int m = 0; m < 16; m++) begin
            apply(2'b00, d, s, 4'(m), 8'h5A);
            check("R1 R2 insert sweep", result, model_insert(d, s, 4'(m)));
        end
    endtask

    task automatic t_lane_order();
        apply(2'b00, 32'h11223344, 32'h000000AB, 4'b1000, 8'h0);
        check("R3 mask bit 3 hits top byte", result, 32'hAB223344);
        apply(2'b00, 32'h11223344, 32'h000000AB, 4'b0001, 8'h0);
        check("R3 mask bit 0 hits low byte", result, 32'h112233AB);
    endtask

    task automatic t_gather_sweep(input logic [31:0] s);
        for (int m = 0; m < 16; m++) begin
            apply(2'b01, 32'hDEADBEEF, s, 4'(m), 8'h33);
            check("R4 gather sweep", result, model_gather(s, 4'(m)));
        end
    endtask

    task automatic t_gather_max();
        apply(2'b01, 32'h0, 32'hFFFFFFFF, 4'hF, 8'h0);
        check("R5 gather ceiling", result, 32'h000003FC);
        apply(2'b01, 32'h0, 32'h80FF0102, 4'b1010, 8'h0);
        check("R4 gather lanes 3 and 1", result, 32'h00000081);
    endtask

    task automatic t_mask_zero();
        apply(2'b00, 32'hCAFEF00D, 32'h12345678, 4'h0, 8'h0);
        check("R6 insert empty mask", result, 32'hCAFEF00D);
        apply(2'b01, 32'hCAFEF00D, 32'hFFFFFFFF, 4'h0, 8'h0);
        check("R6 gather empty mask", result, 32'h0);
    endtask

    task automatic t_ldimm();
        apply(2'b10, 32'h0, 32'h0, 4'h0, 8'h80);
        check("R7 ldimm 0x80", result, 32'hFFFFFF80);
        apply(2'b10, 32'h0, 32'h0, 4'h0, 8'h7F);
        check("R7 ldimm 0x7F", result, 32'h0000007F);
        apply(2'b10, 32'h0, 32'h0, 4'h0, 8'hFF);
        check("R7 ldimm 0xFF", result, 32'hFFFFFFFF);
        apply(2'b10, 32'h0, 32'h0, 4'h0, 8'h00);
        check("R7 ldimm 0x00", result, 32'h0);
    endtask

    task automatic t_shiftin_chain();
        logic [31:0] acc = 32'hA5A5A5A5;
        logic [7:0]  bytes [4] = '{8'h12, 8'h34, 8'h56, 8'h78};
        for (int k = 0; k < 4; k++) begin
            apply(2'b11, acc, 32'h0, 4'h0, bytes[k]);
            acc = result;
        end
        check("R8 four-step constant drops old top bytes", acc, 32'h12345678);
        apply(2'b11, 32'hFF000001, 32'h0, 4'h0, 8'h02);
        check("R8 top byte discarded", result, 32'h00000102);
    endtask

    task automatic t_ignored_inputs();
        apply(2'b10, 32'hFFFFFFFF, 32'hFFFFFFFF, 4'hF, 8'h05);
        check("R9 ldimm ignores dst src mask", result, 32'h00000005);
        apply(2'b01, 32'h0, 32'h01020304, 4'hF, 8'h0);
        check("R9 gather dst zero", result, 32'h0000000A);
        apply(2'b01, 32'hFFFFFFFF, 32'h01020304, 4'hF, 8'hFF);
        check("R9 gather ignores dst", result, 32'h0000000A);
        apply(2'b11, 32'h00ABCDEF, 32'hFFFFFFFF, 4'hF, 8'h01);
        check("R9 shiftin ignores src mask", result, 32'hABCDEF01);
    endtask

    initial begin
        op = '0; dst = '0; src = '0; mask = '0; imm = '0;
        repeat (2) @(posedge clk);
        t_idle();
        t_insert_sweep(32'h11223344, 32'hFFFFFF9C);
        t_insert_sweep(32'h00000000, 32'h000000FF);
        t_lane_order();
        t_gather_sweep(32'hFF7F0180);
        t_gather_sweep(32'h01020408);
        t_gather_max();
        t_mask_zero();
        t_ldimm();
        t_shiftin_chain();
        t_ignored_inputs();
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog all requirements actual=hung expected=complete");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule